// File: doc/BRIEF.md
# Addressed Single-Bit Boolean Decision Unit

This block is the decision engine of a microcoded controller. Each operation carries two source bit addresses, one destination bit address and a four-bit function code. In one clock the unit reads the two source bits from an internal flag file, evaluates the selected two-input Boolean function of them, stores the outcome in the destination flag and returns it on a registered result output. Because the function code is a complete truth table, every one of the sixteen two-input functions is available. No dedicated decision gates are needed for each microprogram branch.

Testing a whole register for zero does not pass through the two-input path. A separate detector reduces a multi-bit input word to one flag, and a reserved source address feeds that flag into the function. A trap hook watches one chosen flag address. When trapping is armed and an operation writes the chosen trap value to that address, the unit emits a single-cycle trap request. Whatever services the trap sits outside the block.

Top module: `bit_alter_unit`

## Requirements
- R1: After a synchronous reset every flag in the file reads 0, and `res_valid` and `trap_req` are 0.
- R2: The result of an operation is `func[{a,b}]`, where `a` is the bit read at `src_a` (index bit 1) and `b` the bit read at `src_b` (index bit 0). For example, 4'b1000 is AND, 4'b0110 is XOR and 4'b1100 copies `a`.
- R3: An operation stores its result in the flag at `dst` when `dst` < NBITS, and later operations read that stored value.
- R4: Both source reads see the flag values from before the operation's own write, so an operation whose `dst` equals a source still yields the truth-table result of the old values.
- R5: Source address NBITS (32 by default) reads 1 when `zd_word` is all zeros and 0 otherwise.
- R6: Source addresses above NBITS read 0, and a `dst` of NBITS or above changes no flag.
- R7: A cycle with `op_valid` low changes no flag and raises neither `res_valid` nor `trap_req`.
- R8: `res_valid` and `result` update on the clock edge that accepts an operation, and `res_valid` stays high only for that one cycle.
- R9: `trap_req` is high for exactly the cycle after an accepted operation in which `trap_en` is 1, `dst` equals `trap_addr`, `dst` < NBITS, and the result equals `trap_val`.
- R10: `trap_req` stays low when trapping is disarmed, when the address differs, or when the written value differs from `trap_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept an operation this cycle |
| src_a | input | 6 | First source bit address (truth-table index bit 1) |
| src_b | input | 6 | Second source bit address (truth-table index bit 0) |
| dst | input | 6 | Destination bit address |
| func | input | 4 | Truth table of the two-input function |
| zd_word | input | 16 | Word tested by the zero detector |
| trap_en | input | 1 | Arm the trap hook |
| trap_addr | input | 6 | Flag address watched by the trap hook |
| trap_val | input | 1 | Written value that fires the trap |
| result | output | 1 | Result of the last accepted operation |
| res_valid | output | 1 | One-cycle strobe marking a fresh result |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The hardest situation to reach is the combination of an armed trap, a matching address and a matching written value. That value depends on flag contents built up by earlier operations. Random stimulus seldom lines all three up, so the bench steers `trap_addr` toward the current `dst` in a share of the random operations and adds directed writes of both polarities. A second awkward case is a destination that equals a source. Directed read-modify-write operations cover it, using XOR and NAND on a single flag, and the flag is then read back through the copy function.

// File: rtl/bau_pkg.sv
package bau_pkg;

    typedef logic [3:0] func_t;

    localparam func_t FN_AND  = 4'b1000;
    localparam func_t FN_XOR  = 4'b0110;
    localparam func_t FN_CPYA = 4'b1100;
    localparam func_t FN_NAND = 4'b0111;

    typedef struct packed {
        logic a;
        logic b;
    } bit_pair_t;

    function automatic logic eval_fn(func_t f, bit_pair_t p);
        return f[{p.a, p.b}];
    endfunction

endpackage

// File: rtl/bau_zero_det.sv
module bau_zero_det #(
    parameter int ZW = 16
) (
    input  logic [ZW-1:0] word_i,
    output logic          zero_o
);
    logic [ZW:0] chain;

    assign chain[0] = 1'b1;
    for (genvar i = 0; i < ZW; i++) begin : g_red
        assign chain[i+1] = chain[i] & ~word_i[i];
    end

    assign zero_o = chain[ZW];
endmodule

// File: rtl/bau_bitfile.sv
module bau_bitfile #(
    parameter int NBITS = 32,
    parameter int AW    = $clog2(NBITS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic          zero_i,
    output logic          rdata_a,
    output logic          rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata
);
    localparam logic [AW-1:0] ZSEL = AW'(NBITS);

    logic [NBITS-1:0] flags;

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (we && waddr == AW'(i))
                flags[i] <= wdata;
        end
    end

    always_comb begin
        rdata_a = 1'b0;
        rdata_b = 1'b0;
        for (int i = 0; i < NBITS; i++) begin
            if (raddr_a == AW'(i)) rdata_a = flags[i];
            if (raddr_b == AW'(i)) rdata_b = flags[i];
        end
        if (raddr_a == ZSEL) rdata_a = zero_i;
        if (raddr_b == ZSEL) rdata_b = zero_i;
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(flags));

    // R6
    oor_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr >= ZSEL) |=> $stable(flags));
endmodule

// File: rtl/bau_trap.sv
module bau_trap #(
    parameter int NBITS = 32,
    parameter int AW    = $clog2(NBITS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire_i,
    input  logic [AW-1:0] dst_i,
    input  logic          wbit_i,
    input  logic          arm_i,
    input  logic [AW-1:0] watch_i,
    input  logic          match_val_i,
    output logic          trap_o
);
    localparam logic [AW-1:0] ZSEL = AW'(NBITS);

    logic hit;

    always_comb begin
        hit = fire_i && arm_i && (dst_i == watch_i) && (dst_i < ZSEL)
              && (wbit_i == match_val_i);
    end

    always_ff @(posedge clk) begin
        if (rst) trap_o <= 1'b0;
        else     trap_o <= hit;
    end

    // R9
    trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $past(fire_i && arm_i));

    // R10
    trap_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !arm_i |=> !trap_o);
endmodule

// File: rtl/bit_alter_unit.sv
module bit_alter_unit
    import bau_pkg::*;
#(
    parameter int NBITS = 32,
    parameter int ZW    = 16,
    parameter int AW    = $clog2(NBITS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic [AW-1:0] dst,
    input  logic [3:0]    func,
    input  logic [ZW-1:0] zd_word,
    input  logic          trap_en,
    input  logic [AW-1:0] trap_addr,
    input  logic          trap_val,
    output logic          result,
    output logic          res_valid,
    output logic          trap_req
);
    logic      zero_flag;
    bit_pair_t pair;
    logic      new_bit;

    bau_zero_det #(.ZW(ZW)) u_zd (
        .word_i (zd_word),
        .zero_o (zero_flag)
    );

    bau_bitfile #(.NBITS(NBITS), .AW(AW)) u_file (
        .clk     (clk),
        .rst     (rst),
        .raddr_a (src_a),
        .raddr_b (src_b),
        .zero_i  (zero_flag),
        .rdata_a (pair.a),
        .rdata_b (pair.b),
        .we      (op_valid),
        .waddr   (dst),
        .wdata   (new_bit)
    );

    always_comb new_bit = eval_fn(func_t'(func), pair);

    bau_trap #(.NBITS(NBITS), .AW(AW)) u_trap (
        .clk         (clk),
        .rst         (rst),
        .fire_i      (op_valid),
        .dst_i       (dst),
        .wbit_i      (new_bit),
        .arm_i       (trap_en),
        .watch_i     (trap_addr),
        .match_val_i (trap_val),
        .trap_o      (trap_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) result <= new_bit;
        end
    end

    // R8
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !trap_req));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(result));
endmodule

// File: tb/bit_alter_unit_bench.sv
`timescale 1ns/1ps
module bit_alter_unit_bench;
    localparam int NBITS = 32;
    localparam int ZW    = 16;
    localparam int AW    = $clog2(NBITS) + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          op_valid;
    logic [AW-1:0] src_a, src_b, dst, trap_addr;
    logic [3:0]    func;
    logic [ZW-1:0] zd_word;
    logic          trap_en, trap_val;
    logic          result, res_valid, trap_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [NBITS-1:0] mbits;

    always #2 clk = ~clk;

    bit_alter_unit #(.NBITS(NBITS), .ZW(ZW)) u_bit_alter_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .src_a(src_a), .src_b(src_b),
        .dst(dst), .func(func), .zd_word(zd_word), .trap_en(trap_en),
        .trap_addr(trap_addr), .trap_val(trap_val), .result(result),
        .res_valid(res_valid), .trap_req(trap_req)
    );

    function automatic logic mread(int addr, logic [ZW-1:0] zw);
        if (addr < NBITS)  return mbits[addr];
        if (addr == NBITS) return (zw == '0);
        return 1'b0;
    endfunction

    task automatic chk(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_op(int a, int b, int d, logic [3:0] f, logic [ZW-1:0] zw,
                         logic ten, int ta, logic tv, string req);
        logic ea, eb, er, et;
        ea = mread(a, zw);
        eb = mread(b, zw);
        er = f[{ea, eb}];
        et = ten && (d == ta) && (d < NBITS) && (er == tv);
        @(negedge clk);
        op_valid = 1'b1; src_a = AW'(a); src_b = AW'(b); dst = AW'(d);
        func = f; zd_word = zw; trap_en = ten; trap_addr = AW'(ta); trap_val = tv;
        @(posedge clk); #1;
        chk(result, er, req, "result");
        chk(res_valid, 1'b1, "R8", "res_valid");
        chk(trap_req, et, et ? "R9" : "R10", "trap_req");
        if (d < NBITS) mbits[d] = er;
        @(negedge clk);
        op_valid = 1'b0; trap_en = 1'b0;
    endtask

    task automatic probe(int i, string req);
        do_op(i, 0, NBITS + 1, 4'b1100, 16'h1, 1'b0, 0, 1'b0, req);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; op_valid = 1'b0; src_a = '0; src_b = '0; dst = '0;
        func = '0; zd_word = '0; trap_en = 1'b0; trap_addr = '0; trap_val = 1'b0;
        mbits = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(res_valid, 1'b0, "R1", "res_valid after reset");
        chk(trap_req, 1'b0, "R1", "trap_req after reset");
        for (int i = 0; i < NBITS; i++) probe(i, "R1");

        // R2: every function on every input pair (flags 0 and 1 prepared)
        do_op(0, 0, 1, 4'b1111, 16'h1, 1'b0, 0, 1'b0, "R3");
        for (int f = 0; f < 16; f++)
            for (int p = 0; p < 4; p++)
                do_op(p[1] ? 1 : 0, p[0] ? 1 : 0, 5, 4'(f), 16'h1, 1'b0, 0, 1'b0, "R2");

        // R3: write then read back
        do_op(1, 1, 7, 4'b1100, 16'h1, 1'b0, 0, 1'b0, "R3");
        probe(7, "R3");

        // R4: destination equals source (XOR toggles, NAND toggles)
        do_op(7, 1, 7, 4'b0110, 16'h1, 1'b0, 0, 1'b0, "R4");
        probe(7, "R4");
        do_op(7, 7, 7, 4'b0111, 16'h1, 1'b0, 0, 1'b0, "R4");
        probe(7, "R4");

        // R5: zero detector as source
        do_op(NBITS, 1, 9, 4'b1000, 16'h0000, 1'b0, 0, 1'b0, "R5");
        do_op(NBITS, 1, 9, 4'b1000, 16'h8000, 1'b0, 0, 1'b0, "R5");
        do_op(0, NBITS, 9, 4'b0101, 16'h0000, 1'b0, 0, 1'b0, "R5");

        // R6: high source reads 0, out-of-range destination ignored
        do_op(NBITS + 3, 1, 10, 4'b1100, 16'h0, 1'b0, 0, 1'b0, "R6");
        do_op(1, 1, NBITS, 4'b0000, 16'h0, 1'b1, NBITS, 1'b0, "R6");
        do_op(1, 1, NBITS + 5, 4'b0000, 16'h0, 1'b0, 0, 1'b0, "R6");
        probe(1, "R6");

        // R7: idle cycle with noisy inputs
        @(negedge clk);
        src_a = 6'd1; src_b = 6'd1; dst = 6'd1; func = 4'b0000;
        trap_en = 1'b1; trap_addr = 6'd1; trap_val = 1'b0;
        @(posedge clk); #1;
        chk(res_valid, 1'b0, "R7", "res_valid idle");
        chk(trap_req, 1'b0, "R7", "trap_req idle");
        @(negedge clk); trap_en = 1'b0;
        @(posedge clk); #1;
        chk(res_valid, 1'b0, "R8", "res_valid one-cycle");
        probe(1, "R7");

        // R9/R10: trap directed
        do_op(1, 1, 12, 4'b1100, 16'h1, 1'b1, 12, 1'b1, "R9");
        @(posedge clk); #1;
        chk(trap_req, 1'b0, "R9", "trap pulse width");
        do_op(1, 1, 12, 4'b0000, 16'h1, 1'b1, 12, 1'b0, "R9");
        do_op(1, 1, 12, 4'b1100, 16'h1, 1'b1, 12, 1'b0, "R10");
        do_op(1, 1, 12, 4'b1100, 16'h1, 1'b1, 13, 1'b1, "R10");
        do_op(1, 1, 12, 4'b1100, 16'h1, 1'b0, 12, 1'b1, "R10");

        // Random mix, trap address often steered to destination
        for (int n = 0; n < 400; n++) begin
            int a, b, d, ta;
            logic [ZW-1:0] zw;
            a  = $urandom % (NBITS + 3);
            b  = $urandom % (NBITS + 3);
            d  = $urandom % (NBITS + 2);
            ta = ($urandom % 2) ? d : ($urandom % NBITS);
            zw = ($urandom % 3 == 0) ? '0 : ZW'($urandom);
            do_op(a, b, d, 4'($urandom), zw, 1'($urandom), ta, 1'($urandom), "R2");
        end
        for (int i = 0; i < NBITS; i++) probe(i, "R3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule